// File: doc/BRIEF.md
# Interval Load and Fair-Share Estimator

This block sits at an output port that carries elastic, feedback-controlled cell traffic. It cuts time into equal averaging intervals whose length in clock cycles is programmable. During an interval it counts the elastic cells it accepts and the higher-priority cells reported to it, and it marks which connections sent at least one cell. At each interval boundary it works out a set of fixed-point figures for a per-connection rate allocator. These figures are the capacity left over for elastic traffic, the load factor and the fair share. It also moves the maximum-allocation pair forward from one interval to the next.

All rates are unsigned Q8.8 values in units of cells per interval, so 1.0 is 256. Every connection has an activity level. The level returns to 1.0 when the connection is seen and shrinks by a fixed factor after each interval in which it is silent. The active-connection count is the fractional sum of these levels. The input rate and the leftover capacity pass through exponential averages. The target capacity comes from a separate queue-control block. The allocator raises the current maximum allocation through its own rate port.

Elastic cells arrive on a valid/ready port. A cell is accepted in a cycle where `cell_valid` and `cell_ready` are both high. From the cycle after an interval boundary until the cycle the results appear, the block lowers `cell_ready` while it sweeps the activity array. During that time the sender must hold `cell_valid` and `cell_vc` steady. A cell held off in this way is counted in the new interval. Higher-priority cell pulses and allocation-rate updates are plain inputs and are never stalled.

Top module: `interval_load_estimator`

## Requirements
- R1: `est_done` pulses for exactly one cycle per interval. Consecutive pulses are `cfg_interval_len` cycles apart. A new length written early in an interval applies to that interval.
- R2: The capacity sample at an interval end is `cfg_link_cap` minus (higher-priority cell count × 256), clamped at 0. Counts saturate at 255. `abr_capacity` shows the averaged sample.
- R3: `load_factor` = floor(averaged input rate × 256 / `target_cap`), saturated to 0xFFFF. It is 0xFFFF when `target_cap` is 0. It holds its value between `est_done` pulses.
- R4: `fair_share` = floor(`target_cap` × 256 / `active_count`), saturated to 0xFFFF. It equals `target_cap` when `active_count` is 0.
- R5: At each interval end, `max_alloc_prev` takes the current maximum allocation and `max_alloc_curr` takes the new `fair_share`. After reset both hold 0, which is the reset fair share.
- R6: Between interval ends, an `er_valid` pulse raises `max_alloc_curr` to `er_rate` if `er_rate` is larger.
- R7: A connection's activity level becomes 256 if the connection had a cell accepted during the interval. Otherwise it becomes floor(level × 240 / 256). `active_count` is the sum of all 16 levels.
- R8: Both averages follow avg = floor((avg × 51 + sample × 205) / 256), starting from 0. The input-rate sample is min(count, 255) × 256.
- R9: `cell_ready` is low from the cycle after the boundary through the cycle before `est_done`. A cell held off during that time is accepted in the `est_done` cycle and counts in the next interval.
- R10: After reset all result outputs are 0, `est_done` is low and `cell_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval_len | input | 16 | Interval length in cycles (at least 19) |
| cfg_link_cap | input | 16 | Link capacity, Q8.8 cells per interval |
| target_cap | input | 16 | Target elastic capacity from queue control, Q8.8 |
| cell_valid | input | 1 | Elastic cell offered |
| cell_ready | output | 1 | Elastic cell can be accepted |
| cell_vc | input | 4 | Connection index of the offered cell |
| hp_cell | input | 1 | One higher-priority cell sent this cycle |
| er_valid | input | 1 | Allocator reports a granted rate |
| er_rate | input | 16 | Granted rate, Q8.8 |
| load_factor | output | 16 | Load factor, Q8.8 |
| fair_share | output | 16 | Fair share, Q8.8 |
| active_count | output | 16 | Fractional active-connection count, Q8.8 |
| abr_capacity | output | 16 | Averaged leftover elastic capacity, Q8.8 |
| max_alloc_prev | output | 16 | Maximum allocation of the previous interval |
| max_alloc_curr | output | 16 | Maximum allocation so far this interval |
| est_done | output | 1 | One-cycle pulse: results updated |

## Verification
The hardest condition to create from the ports is a cell offered while the activity sweep is running. The stimulus waits until `cell_ready` falls after a boundary and then raises `cell_valid` and holds it. It checks that acceptance happens in the `est_done` cycle and that the held connection shows up at full activity one interval later. Several silent intervals are chained so that the decay compounds, and every connection is then touched at once. A zero target and a higher-priority count above link capacity drive the saturation paths.

// File: rtl/est_pkg.sv
package est_pkg;
  typedef logic [15:0] q88_t;
  localparam q88_t Q_ONE = 16'd256;

  function automatic q88_t sat_q88(input logic [23:0] v);
    return (v[23:16] != 8'd0) ? 16'hFFFF : v[15:0];
  endfunction
endpackage

// File: rtl/est_interval_timer.sv
module est_interval_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] len,
  output logic               tick
);
  logic [TIMER_W-1:0] cnt;

  assign tick = (cnt >= len - TIMER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + TIMER_W'(1);
  end
endmodule

// File: rtl/est_activity_sweep.sv
module est_activity_sweep
  import est_pkg::*;
#(
  parameter int NUM_VC   = 16,
  parameter int DECAY_Q8 = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NUM_VC-1:0] seen,
  output logic              busy,
  output logic              fin,
  output q88_t              sum
);
  localparam int IW = $clog2(NUM_VC);

  q88_t           level [NUM_VC];
  logic [IW-1:0]  idx;
  q88_t           acc;
  logic [23:0]    prod;
  q88_t           nxt;

  assign prod = 24'(level[idx]) * 24'(DECAY_Q8);
  assign nxt  = seen[idx] ? Q_ONE : prod[23:8];
  assign sum  = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      fin  <= 1'b0;
      idx  <= '0;
      acc  <= '0;
      for (int i = 0; i < NUM_VC; i++) level[i] <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        acc  <= '0;
      end else if (busy) begin
        level[idx] <= nxt;
        acc        <= acc + nxt;
        if (idx == IW'(NUM_VC - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/est_ema.sv
module est_ema
  import est_pkg::*;
#(
  parameter int ALPHA_Q8 = 205
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  q88_t sample,
  output q88_t avg
);
  generate
    if (ALPHA_Q8 >= 256) begin : g_raw
      always_ff @(posedge clk) begin
        if (!rst_n)    avg <= '0;
        else if (load) avg <= sample;
      end
    end else begin : g_smooth
      logic [24:0] mix;
      assign mix = 25'(avg) * 25'(256 - ALPHA_Q8) + 25'(sample) * 25'(ALPHA_Q8);
      always_ff @(posedge clk) begin
        if (!rst_n)    avg <= '0;
        else if (load) avg <= mix[23:8];
      end
    end
  endgenerate
endmodule

// File: rtl/interval_load_estimator.sv
module interval_load_estimator
  import est_pkg::*;
#(
  parameter int NUM_VC   = 16,
  parameter int CNT_W    = 8,
  parameter int TIMER_W  = 16,
  parameter int ALPHA_Q8 = 205,
  parameter int DECAY_Q8 = 240,
  localparam int VC_W    = $clog2(NUM_VC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] cfg_interval_len,
  input  logic [15:0]        cfg_link_cap,
  input  logic [15:0]        target_cap,
  input  logic               cell_valid,
  output logic               cell_ready,
  input  logic [VC_W-1:0]    cell_vc,
  input  logic               hp_cell,
  input  logic               er_valid,
  input  logic [15:0]        er_rate,
  output logic [15:0]        load_factor,
  output logic [15:0]        fair_share,
  output logic [15:0]        active_count,
  output logic [15:0]        abr_capacity,
  output logic [15:0]        max_alloc_prev,
  output logic [15:0]        max_alloc_curr,
  output logic               est_done
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  state_t            st;
  logic              tick, acc_cell, sw_busy, sw_fin;
  logic [CNT_W-1:0]  abr_cnt, hp_cnt, abr_snap, hp_snap;
  logic [CNT_W:0]    abr_inc, hp_inc;
  logic [NUM_VC-1:0] seen_bits, vc_bit;
  q88_t              in_sample, hp_rate, cap_sample, in_avg, cap_avg, act_sum;
  q88_t              lf_next, fs_next, roll_max;
  logic [23:0]       lf_quo, fs_quo;
  logic [15:0]       lf_den, fs_den;

  est_interval_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .len(cfg_interval_len), .tick(tick)
  );

  assign cell_ready = (st == ST_IDLE);
  assign acc_cell   = cell_valid & cell_ready;
  assign vc_bit     = acc_cell ? (NUM_VC'(1) << cell_vc) : '0;

  // Snapshot includes any event arriving in the boundary cycle itself.
  assign abr_inc  = {1'b0, abr_cnt} + {{CNT_W{1'b0}}, acc_cell};
  assign hp_inc   = {1'b0, hp_cnt}  + {{CNT_W{1'b0}}, hp_cell};
  assign abr_snap = abr_inc[CNT_W] ? CNT_MAX : abr_inc[CNT_W-1:0];
  assign hp_snap  = hp_inc[CNT_W]  ? CNT_MAX : hp_inc[CNT_W-1:0];

  assign in_sample  = q88_t'(abr_snap) << 8;
  assign hp_rate    = q88_t'(hp_snap) << 8;
  assign cap_sample = (cfg_link_cap > hp_rate) ? (cfg_link_cap - hp_rate) : '0;

  est_ema #(.ALPHA_Q8(ALPHA_Q8)) u_in_avg (
    .clk(clk), .rst_n(rst_n), .load(tick), .sample(in_sample), .avg(in_avg)
  );
  est_ema #(.ALPHA_Q8(ALPHA_Q8)) u_cap_avg (
    .clk(clk), .rst_n(rst_n), .load(tick), .sample(cap_sample), .avg(cap_avg)
  );

  est_activity_sweep #(.NUM_VC(NUM_VC), .DECAY_Q8(DECAY_Q8)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(tick & (st == ST_IDLE)), .seen(seen_bits),
    .busy(sw_busy), .fin(sw_fin), .sum(act_sum)
  );

  // Boundary arithmetic, evaluated in the sweep's final cycle.
  assign lf_den  = (target_cap == 16'd0) ? 16'd1 : target_cap;
  assign fs_den  = (act_sum == 16'd0) ? 16'd1 : act_sum;
  assign lf_quo  = {in_avg, 8'h00} / {8'h00, lf_den};
  assign fs_quo  = {target_cap, 8'h00} / {8'h00, fs_den};
  assign lf_next = (target_cap == 16'd0) ? 16'hFFFF : sat_q88(lf_quo);
  assign fs_next = (act_sum == 16'd0) ? target_cap : sat_q88(fs_quo);
  assign roll_max = (er_valid && er_rate > max_alloc_curr) ? er_rate : max_alloc_curr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      abr_cnt   <= '0;
      hp_cnt    <= '0;
      seen_bits <= '0;
    end else begin
      if (st == ST_IDLE && tick) st <= ST_RUN;
      else if (sw_fin)           st <= ST_IDLE;

      if (tick) begin
        abr_cnt <= '0;
        hp_cnt  <= '0;
      end else begin
        if (acc_cell && abr_cnt != CNT_MAX) abr_cnt <= abr_cnt + CNT_W'(1);
        if (hp_cell && hp_cnt != CNT_MAX)   hp_cnt  <= hp_cnt + CNT_W'(1);
      end

      if (sw_fin) seen_bits <= '0;
      else        seen_bits <= seen_bits | vc_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_factor    <= '0;
      fair_share     <= '0;
      active_count   <= '0;
      abr_capacity   <= '0;
      max_alloc_prev <= '0;
      max_alloc_curr <= '0;
      est_done       <= 1'b0;
    end else begin
      est_done <= sw_fin;
      if (sw_fin) begin
        load_factor    <= lf_next;
        fair_share     <= fs_next;
        active_count   <= act_sum;
        abr_capacity   <= cap_avg;
        max_alloc_prev <= roll_max;
        max_alloc_curr <= fs_next;
      end else if (er_valid && er_rate > max_alloc_curr) begin
        max_alloc_curr <= er_rate;
      end
    end
  end
endmodule

// File: rtl/est_checker.sv
module est_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] target_cap,
  input logic        cell_ready,
  input logic        er_valid,
  input logic [15:0] er_rate,
  input logic [15:0] load_factor,
  input logic [15:0] fair_share,
  input logic [15:0] active_count,
  input logic [15:0] max_alloc_prev,
  input logic [15:0] max_alloc_curr,
  input logic        est_done
);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    est_done |=> !est_done);

  a_r3_zero_target: assert property (@(posedge clk) disable iff (!rst_n)
    (est_done && $past(target_cap) == 16'd0) |-> load_factor == 16'hFFFF);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !est_done |-> $stable(load_factor));

  a_r4_zero_active: assert property (@(posedge clk) disable iff (!rst_n)
    (est_done && active_count == 16'd0) |-> fair_share == $past(target_cap));

  a_r5_curr_reload: assert property (@(posedge clk) disable iff (!rst_n)
    est_done |-> max_alloc_curr == fair_share);

  a_r5_prev_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    est_done |-> max_alloc_prev >= $past(max_alloc_curr));

  a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
    er_valid ##1 !est_done |-> max_alloc_curr >= $past(er_rate));

  a_r9_stall_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    est_done |-> $past(!cell_ready));
endmodule

bind interval_load_estimator est_checker u_chk (
  .clk(clk), .rst_n(rst_n), .target_cap(target_cap), .cell_ready(cell_ready),
  .er_valid(er_valid), .er_rate(er_rate), .load_factor(load_factor),
  .fair_share(fair_share), .active_count(active_count),
  .max_alloc_prev(max_alloc_prev), .max_alloc_curr(max_alloc_curr),
  .est_done(est_done)
);

// File: tb/interval_load_estimator_test.sv
`timescale 1ns/1ps
module interval_load_estimator_test;
  localparam int NVC  = 16;
  localparam int LINK = 10240;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_interval_len = 16'd80;
  logic [15:0] cfg_link_cap = 16'(LINK);
  logic [15:0] target_cap = 16'd5120;
  logic        cell_valid = 1'b0, hp_cell = 1'b0, er_valid = 1'b0;
  logic [3:0]  cell_vc = '0;
  logic [15:0] er_rate = '0;
  logic        cell_ready, est_done;
  logic [15:0] load_factor, fair_share, active_count, abr_capacity;
  logic [15:0] max_alloc_prev, max_alloc_curr;

  always #2.5 clk = ~clk;

  interval_load_estimator uut (
    .clk(clk), .rst_n(rst_n), .cfg_interval_len(cfg_interval_len),
    .cfg_link_cap(cfg_link_cap), .target_cap(target_cap),
    .cell_valid(cell_valid), .cell_ready(cell_ready), .cell_vc(cell_vc),
    .hp_cell(hp_cell), .er_valid(er_valid), .er_rate(er_rate),
    .load_factor(load_factor), .fair_share(fair_share),
    .active_count(active_count), .abr_capacity(abr_capacity),
    .max_alloc_prev(max_alloc_prev), .max_alloc_curr(max_alloc_curr),
    .est_done(est_done)
  );

  typedef struct { int lf; int fs; int act; int cap; int mp; int mc; int gap; } exp_t;
  exp_t sbq[$];

  int n_cmp = 0, n_bad = 0;
  longint cyc = 0, last_done = 0;
  int m_level[NVC];
  bit m_seen[NVC];
  int m_abr = 0, m_hp = 0, m_in = 0, m_cap = 0, m_max = 0, cur_len = 80;
  bit first_item = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ema(int avg, int s);
    return (avg * 51 + s * 205) >>> 8;
  endfunction

  // Driver side: stimulus plus reference model.
  task automatic send_cell(int vc);
    cell_vc = 4'(vc); cell_valid = 1'b1;
    while (!cell_ready) @(negedge clk);
    @(negedge clk);
    cell_valid = 1'b0;
    m_abr++; m_seen[vc] = 1'b1;
  endtask

  task automatic send_hp(int n);
    for (int i = 0; i < n; i++) begin
      hp_cell = 1'b1; @(negedge clk); hp_cell = 1'b0; m_hp++;
    end
  endtask

  task automatic send_er(int r);
    er_rate = 16'(r); er_valid = 1'b1; @(negedge clk); er_valid = 1'b0;
    if (r > m_max) m_max = r;
  endtask

  task automatic close_interval();
    exp_t e;
    int s_in, hp, cs, sum, t;
    s_in = ((m_abr > 255) ? 255 : m_abr) * 256;
    hp   = ((m_hp > 255) ? 255 : m_hp) * 256;
    cs   = (LINK > hp) ? LINK - hp : 0;
    m_in  = ema(m_in, s_in);
    m_cap = ema(m_cap, cs);
    sum = 0;
    for (int v = 0; v < NVC; v++) begin
      m_level[v] = m_seen[v] ? 256 : (m_level[v] * 240) >>> 8;
      sum += m_level[v];
      m_seen[v] = 1'b0;
    end
    t = int'(target_cap);
    e.lf  = (t == 0) ? 65535 : (((m_in * 256) / t > 65535) ? 65535 : (m_in * 256) / t);
    e.fs  = (sum == 0) ? t : (((t * 256) / sum > 65535) ? 65535 : (t * 256) / sum);
    e.act = sum;
    e.cap = m_cap;
    e.mp  = m_max;
    e.mc  = e.fs;
    e.gap = first_item ? 0 : cur_len;
    first_item = 1'b0;
    m_max = e.fs;
    m_abr = 0; m_hp = 0;
    sbq.push_back(e);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!est_done);
  endtask

  // Monitor: pops one expected result per done pulse.
  always @(negedge clk) begin
    if (rst_n && est_done) begin
      if (sbq.size() == 0) begin
        check("R1 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check("R3 R8 load_factor", int'(load_factor), e.lf);
        check("R4 fair_share", int'(fair_share), e.fs);
        check("R7 active_count", int'(active_count), e.act);
        check("R2 R8 abr_capacity", int'(abr_capacity), e.cap);
        check("R6 max_alloc_prev", int'(max_alloc_prev), e.mp);
        check("R5 max_alloc_curr", int'(max_alloc_curr), e.mc);
        if (e.gap != 0) check("R1 done spacing", int'(cyc - last_done), e.gap);
      end
      last_done = cyc;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int v = 0; v < NVC; v++) begin m_level[v] = 0; m_seen[v] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 load_factor", int'(load_factor), 0);
    check("R10 fair_share", int'(fair_share), 0);
    check("R10 max_alloc_prev", int'(max_alloc_prev), 0);
    check("R10 max_alloc_curr", int'(max_alloc_curr), 0);
    check("R10 est_done", int'(est_done), 0);
    check("R10 cell_ready", int'(cell_ready), 1);

    // I0: empty interval, zero active count gives the target (R4)
    close_interval();
    wait_done();

    // I1: two connections, some higher-priority load, one granted rate
    send_cell(0); send_cell(0); send_cell(0); send_cell(5); send_cell(5);
    send_hp(4); send_er(300);
    close_interval();
    wait_done();

    // I2: zero target saturates load factor (R3); connection 5 decays (R7)
    target_cap = 16'd0;
    send_cell(0);
    close_interval();
    wait_done();

    // I3: silent interval, compounding decay
    target_cap = 16'd5120;
    close_interval();
    wait_done();

    // I4: every connection active
    target_cap = 16'd2560;
    for (int v = 0; v < NVC; v++) send_cell(v);
    send_hp(12);
    close_interval();
    wait_done();

    // I5: higher-priority count over link capacity clamps to 0 (R2); large grant (R6)
    send_hp(45); send_er(16'hF000);
    close_interval();
    wait_done();

    // I6: longer interval written early (R1)
    cfg_interval_len = 16'd100; cur_len = 100;
    send_cell(3); send_er(40);
    close_interval();

    // R9: cell offered during the sweep is held until the done cycle
    while (cell_ready) @(negedge clk);
    cell_vc = 4'd7; cell_valid = 1'b1;
    check("R9 ready low in sweep", int'(cell_ready), 0);
    while (!cell_ready) @(negedge clk);
    check("R9 ready returns with done", int'(est_done), 1);
    @(negedge clk);
    cell_valid = 1'b0;
    m_abr++; m_seen[7] = 1'b1;

    // I7: the held cell counts here
    send_cell(9);
    close_interval();
    wait_done();

    @(negedge clk);
    check("R1 queue drained", sbq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule